// File: doc/BRIEF.md
# ADC Sample Buffer with Occupancy Flags

This block is a four-entry first-in first-out store placed between an analog-to-digital conversion engine and a processor read port. Converted samples enter through a conversion-done strobe. A debug write strobe gives a second way in, and both share one write path. The processor takes samples out with a pop strobe. The oldest stored sample is always visible on the read data port while the buffer holds anything.

Five status flags are registered outputs: empty, almost full, full, overflow and underflow. They are computed from the next occupancy level, so they change at the same clock edge as the push or pop that moves the level. The level stays exact when a push and a pop land in the same cycle, at every level. The two error flags are sticky. Only a coded flush command clears them, and the same command empties the buffer.

Top module: `adc_sample_fifo`

## Requirements
- R1: After reset the buffer is empty: `empty` is 1, `rd_valid` is 0, and `almost_full`, `full`, `overflow` and `underflow` are 0.
- R2: Samples leave in the order they were accepted. While `rd_valid` is 1, `rd_data` shows the oldest sample with no clock delay, and a pop moves to the next sample at the clock edge.
- R3: After each edge, `empty` is 1 exactly when the level is 0, `almost_full` is 1 exactly when the level is 3 or 4, and `full` is 1 exactly when the level is 4. `rd_valid` is the inverse of `empty`.
- R4: A push and a pop in the same cycle on a non-empty buffer leave the level unchanged at 1, 3 or 4. The pushed sample is stored, and `overflow` is not set.
- R5: A push while the level is 4 and no pop is made in that cycle discards the pushed sample and sets `overflow`. The stored samples are unchanged.
- R6: A pop while the level is 0 returns no sample, leaves the level at 0 and sets `underflow`.
- R7: When `cmd_valid` is 1 and `cmd_code` equals 3, the next edge empties the buffer and clears `overflow` and `underflow`. A push or pop in that same cycle is ignored. Any other code value has no effect.
- R8: `dbg_push` stores `dbg_data` the same way a conversion push stores `conv_data`. When both strobes are 1 in one cycle, only `conv_data` is stored. That push counts as one push for the overflow rule of R5.
- R9: `overflow` and `underflow` stay 1 through later pushes and pops until a flush clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_push | input | 1 | Conversion-done strobe, pushes `conv_data` |
| conv_data | input | 12 | Converted sample |
| dbg_push | input | 1 | Debug write strobe, pushes `dbg_data` |
| dbg_data | input | 12 | Debug sample |
| rd_pop | input | 1 | Processor pop strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 2 | Command code, value 3 flushes |
| rd_data | output | 12 | Oldest stored sample |
| rd_valid | output | 1 | Buffer holds at least one sample |
| empty | output | 1 | Level is 0 |
| almost_full | output | 1 | Level is 3 or more |
| full | output | 1 | Level is 4 |
| overflow | output | 1 | Sticky: a push was discarded |
| underflow | output | 1 | Sticky: a pop found the buffer empty |

## Verification
A level counter that drifts after a simultaneous push and pop shows up at the very next edge. A flag comes out wrong, or `rd_valid` drops while a sample is still owed. A read pointer that is off by one shows up as soon as the next pop, because `rd_data` no longer matches the oldest sample the scoreboard expects. A write that should have been discarded but was kept, or the other way round, stays hidden until the buffer drains. It then appears as a reordered or extra sample, so every test sequence ends by draining the buffer.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;

    typedef struct packed {
        logic empty;
        logic almost_full;
        logic full;
        logic overflow;
        logic underflow;
    } fifo_flags_t;

    localparam fifo_flags_t FLAGS_RESET = '{empty: 1'b1, almost_full: 1'b0,
                                           full: 1'b0, overflow: 1'b0,
                                           underflow: 1'b0};

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_CONV = 2'd1,
        SRC_DBG  = 2'd2
    } push_src_e;

endpackage

// File: rtl/adc_fifo_push_arb.sv
module adc_fifo_push_arb
    import adc_fifo_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              conv_push,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              dbg_push,
    input  logic [DATA_W-1:0] dbg_data,
    output logic              push_req,
    output logic [DATA_W-1:0] push_data
);

    push_src_e src;

    // The conversion source wins; a debug write in the same cycle is dropped.
    always_comb begin
        if (conv_push)     src = SRC_CONV;
        else if (dbg_push) src = SRC_DBG;
        else               src = SRC_NONE;
    end

    always_comb begin
        push_req  = (src != SRC_NONE);
        unique case (src)
            SRC_CONV: push_data = conv_data;
            SRC_DBG:  push_data = dbg_data;
            default:  push_data = '0;
        endcase
    end

endmodule

// File: rtl/adc_fifo_ctrl.sv
module adc_fifo_ctrl
    import adc_fifo_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic             pop_req,
    input  logic             flush,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic [LVL_W-1:0] level,
    output fifo_flags_t      flags
);

    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(DEPTH);
    localparam logic [LVL_W-1:0] LVL_AF   = LVL_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0] wr_ptr;
        logic [PTR_W-1:0] rd_ptr;
        logic [LVL_W-1:0] level;
        fifo_flags_t      flags;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    logic        pop_ok;
    logic        room;
    logic        wr_ok;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d   = st_q;
        pop_ok = pop_req && (st_q.level != '0);
        room   = (st_q.level != LVL_FULL);
        wr_ok  = push_req && (room || pop_ok);
        wr_en  = wr_ok && !flush;

        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.level  = '0;
            st_d.flags  = FLAGS_RESET;
        end else begin
            if (wr_ok)  st_d.wr_ptr = ptr_step(st_q.wr_ptr);
            if (pop_ok) st_d.rd_ptr = ptr_step(st_q.rd_ptr);
            st_d.level = st_q.level + LVL_W'(wr_ok) - LVL_W'(pop_ok);

            if (push_req && !room && !pop_ok) st_d.flags.overflow = 1'b1;
            if (pop_req && (st_q.level == '0)) st_d.flags.underflow = 1'b1;

            st_d.flags.empty       = (st_d.level == '0);
            st_d.flags.almost_full = (st_d.level >= LVL_AF);
            st_d.flags.full        = (st_d.level == LVL_FULL);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr_ptr <= '0;
            st_q.rd_ptr <= '0;
            st_q.level  <= '0;
            st_q.flags  <= FLAGS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign wr_ptr = st_q.wr_ptr;
    assign rd_ptr = st_q.rd_ptr;
    assign level  = st_q.level;
    assign flags  = st_q.flags;

endmodule

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [PTR_W-1:0]  wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [PTR_W-1:0]  rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot_q [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [DATA_W-1:0] slot_d;

        always_comb begin
            slot_d = slot_q[i];
            if (wr_en && (wr_ptr == PTR_W'(i))) slot_d = wr_data;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[i] <= '0;
            else        slot_q[i] <= slot_d;
        end
    end

    assign rd_data = slot_q[rd_ptr];

endmodule

// File: rtl/adc_sample_fifo.sv
module adc_sample_fifo
    import adc_fifo_pkg::*;
#(
    parameter int DATA_W            = 12,
    parameter int DEPTH             = 4,
    parameter int CMD_W             = 2,
    parameter logic [CMD_W-1:0] FLUSH_CODE = 2'd3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_push,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              dbg_push,
    input  logic [DATA_W-1:0] dbg_data,
    input  logic              rd_pop,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_code,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              empty,
    output logic              almost_full,
    output logic              full,
    output logic              overflow,
    output logic              underflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic              push_req;
    logic [DATA_W-1:0] push_data;
    logic              flush;
    logic              wr_en;
    logic [PTR_W-1:0]  wr_ptr;
    logic [PTR_W-1:0]  rd_ptr;
    logic [LVL_W-1:0]  level_q;
    fifo_flags_t       flags_q;

    assign flush = cmd_valid && (cmd_code == FLUSH_CODE);

    adc_fifo_push_arb #(.DATA_W(DATA_W)) i_arb (
        .conv_push (conv_push),
        .conv_data (conv_data),
        .dbg_push  (dbg_push),
        .dbg_data  (dbg_data),
        .push_req  (push_req),
        .push_data (push_data)
    );

    adc_fifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_req (push_req),
        .pop_req  (rd_pop),
        .flush    (flush),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .level    (level_q),
        .flags    (flags_q)
    );

    adc_fifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (push_data),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data)
    );

    assign rd_valid    = !flags_q.empty;
    assign empty       = flags_q.empty;
    assign almost_full = flags_q.almost_full;
    assign full        = flags_q.full;
    assign overflow    = flags_q.overflow;
    assign underflow   = flags_q.underflow;

endmodule

// File: rtl/adc_fifo_checker.sv
module adc_fifo_checker #(
    parameter int DEPTH = 4,
    parameter int CMD_W = 2,
    parameter logic [CMD_W-1:0] FLUSH_CODE = 2'd3,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             conv_push,
    input logic             dbg_push,
    input logic             rd_pop,
    input logic             cmd_valid,
    input logic [CMD_W-1:0] cmd_code,
    input logic             empty,
    input logic             almost_full,
    input logic             full,
    input logic             overflow,
    input logic             underflow,
    input logic             rd_valid,
    input logic [LVL_W-1:0] level
);

    logic flush;
    logic push;
    assign flush = cmd_valid && (cmd_code == FLUSH_CODE);
    assign push  = conv_push || dbg_push;

    // R3
    full_implies_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> (almost_full && !empty && rd_valid));

    // R4
    coincide_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push && rd_pop && !empty) |=> ($stable(level) && ($past(overflow) || !overflow)));

    // R5
    overflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && push && full && !rd_pop) |=> (overflow && full));

    // R6
    underflow_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && rd_pop && empty && !push) |=> (underflow && empty));

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !overflow && !underflow && !almost_full));

    // R9
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !flush) |=> overflow);

    // R9
    sticky_unf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !flush) |=> underflow);

endmodule

bind adc_sample_fifo adc_fifo_checker #(
    .DEPTH(DEPTH), .CMD_W(CMD_W), .FLUSH_CODE(FLUSH_CODE)
) i_adc_fifo_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_push   (conv_push),
    .dbg_push    (dbg_push),
    .rd_pop      (rd_pop),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .empty       (empty),
    .almost_full (almost_full),
    .full        (full),
    .overflow    (overflow),
    .underflow   (underflow),
    .rd_valid    (rd_valid),
    .level       (level_q)
);

// File: tb/test_adc_sample_fifo.sv
module test_adc_sample_fifo;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          conv_push = 1'b0;
    logic [DW-1:0] conv_data = '0;
    logic          dbg_push = 1'b0;
    logic [DW-1:0] dbg_data = '0;
    logic          rd_pop = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [1:0]    cmd_code = '0;
    logic [DW-1:0] rd_data;
    logic          rd_valid, empty, almost_full, full, overflow, underflow;

    int vectors = 0;
    int fails = 0;
    int cycles = 0;

    logic [DW-1:0] exp_q[$];
    logic          m_ovf = 1'b0;
    logic          m_unf = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_sample_fifo i_adc_sample_fifo (
        .clk(clk), .rst_n(rst_n),
        .conv_push(conv_push), .conv_data(conv_data),
        .dbg_push(dbg_push), .dbg_data(dbg_data),
        .rd_pop(rd_pop), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .rd_data(rd_data), .rd_valid(rd_valid), .empty(empty),
        .almost_full(almost_full), .full(full),
        .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Monitor: compare all outputs to the scoreboard state.
    task automatic observe(input string req);
        int n = exp_q.size();
        chk(req, "empty", int'(empty), int'(n == 0));
        chk(req, "almost_full", int'(almost_full), int'(n >= 3));
        chk(req, "full", int'(full), int'(n == 4));
        chk(req, "rd_valid", int'(rd_valid), int'(n != 0));
        chk(req, "overflow", int'(overflow), int'(m_ovf));
        chk(req, "underflow", int'(underflow), int'(m_unf));
        if (n != 0) chk(req, "rd_data", int'(rd_data), int'(exp_q[0]));
    endtask

    // Driver: apply one cycle of stimulus and update the expected queue.
    task automatic step(input string req, input logic a, input logic [DW-1:0] ad,
                        input logic d, input logic [DW-1:0] dd, input logic p,
                        input logic cv, input logic [1:0] cc);
        logic          do_push;
        logic [DW-1:0] val;
        logic          was_full;
        logic          pop_ok;
        conv_push = a; conv_data = ad; dbg_push = d; dbg_data = dd;
        rd_pop = p; cmd_valid = cv; cmd_code = cc;
        if (cv && cc == 2'd3) begin
            exp_q.delete();
            m_ovf = 1'b0;
            m_unf = 1'b0;
        end else begin
            do_push  = a || d;
            val      = a ? ad : dd;
            was_full = (exp_q.size() == 4);
            pop_ok   = p && (exp_q.size() != 0);
            if (p && !pop_ok) m_unf = 1'b1;
            if (do_push && was_full && !pop_ok) m_ovf = 1'b1;
            if (pop_ok) void'(exp_q.pop_front());
            if (do_push && !(was_full && !pop_ok)) exp_q.push_back(val);
        end
        @(negedge clk);
        conv_push = 1'b0; dbg_push = 1'b0; rd_pop = 1'b0; cmd_valid = 1'b0;
        observe(req);
    endtask

    task automatic push_conv(input string req, input logic [DW-1:0] v);
        step(req, 1'b1, v, 1'b0, '0, 1'b0, 1'b0, 2'd0);
    endtask

    task automatic pop1(input string req);
        step(req, 1'b0, '0, 1'b0, '0, 1'b1, 1'b0, 2'd0);
    endtask

    task automatic drain(input string req);
        while (exp_q.size() != 0) pop1(req);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
                $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
                $finish;
            end
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        // R1: reset state
        observe("R1");
        rst_n = 1'b1;
        @(negedge clk);
        observe("R1");

        // R2 order, R8 debug path
        push_conv("R2", 12'h101);
        step("R8", 1'b0, '0, 1'b1, 12'hD02, 1'b0, 1'b0, 2'd0);
        push_conv("R3", 12'h103);
        drain("R2");

        // R4: coincident push and pop at level 1
        push_conv("R4", 12'h201);
        step("R4", 1'b1, 12'h202, 1'b0, '0, 1'b1, 1'b0, 2'd0);
        // R4: level 3
        push_conv("R3", 12'h203);
        push_conv("R3", 12'h204);
        step("R4", 1'b0, '0, 1'b1, 12'hD05, 1'b1, 1'b0, 2'd0);
        // R4: level 4
        push_conv("R3", 12'h206);
        step("R4", 1'b1, 12'h207, 1'b0, '0, 1'b1, 1'b0, 2'd0);

        // R5: overflow at full, R8 both strobes at full
        push_conv("R5", 12'h2FF);
        step("R8", 1'b1, 12'h2FE, 1'b1, 12'hDFE, 1'b0, 1'b0, 2'd0);
        // R9: sticky overflow survives pops
        pop1("R9");
        // R8: both strobes, not full: only conversion sample kept
        step("R8", 1'b1, 12'h301, 1'b1, 12'hD01, 1'b0, 1'b0, 2'd0);
        drain("R2");

        // R6: underflow
        pop1("R6");
        pop1("R6");
        // R9: sticky underflow through a push
        push_conv("R9", 12'h401);
        // R7: non-flush code has no effect
        step("R7", 1'b0, '0, 1'b0, '0, 1'b0, 1'b1, 2'd2);
        push_conv("R7", 12'h402);
        // R7: flush with push and pop in the same cycle
        step("R7", 1'b1, 12'h4AA, 1'b0, '0, 1'b1, 1'b1, 2'd3);
        // After flush: fill to full and check order
        push_conv("R3", 12'h501);
        step("R3", 1'b0, '0, 1'b1, 12'hD52, 1'b0, 1'b0, 2'd0);
        push_conv("R3", 12'h503);
        push_conv("R3", 12'h504);
        drain("R2");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule